// File: doc/BRIEF.md
# Subscriber Line Hook Supervisor with Automatic Ring Trip

This block watches one subscriber line and decides whether the handset is on-hook or off-hook. Its input is a loop-current-detect bit that is already sampled into the clock domain, together with a one-cycle pulse every millisecond. A change in the raw detect bit becomes the reported hook state only after it has held for a set number of consecutive millisecond ticks. The reported state drives two active-low outputs: a switch-hook flag and an LED drive that mirrors it.

The block also gates the ring relay. The relay follows the ring command from the control register, with two exceptions. While the relay is energised, the hook filter switches to a much longer qualification window, so that AC ringing current does not look like an answered call. After every relay switch-on or switch-off, a blanking interval freezes detection so that relay transients are ignored. Once an off-hook is confirmed, the relay is tripped off at once. It then stays off until the ring command is withdrawn and given again.

Top module: `hook_supervisor`

## Requirements
- R1: After reset, `hook_n` and `led_n` are 1 (on-hook) and `ring_drv` is 0.
- R2: `led_n` always equals `hook_n`.
- R3: The normal window applies when the relay is off and no blanking is active. In that case a differing `det_raw` level becomes the reported state on the 8th consecutive tick at which it still differs. Any cycle in which `det_raw` agrees with the reported state restarts that count.
- R4: `det_raw` = 1 means loop current (off-hook); an accepted off-hook drives `hook_n` low, and an accepted on-hook drives it high. Dial-pulse breaks and makes of 8 ticks or longer are each reported.
- R5: With the line on-hook and no trip latched, `ring_drv` rises on the first clock edge that samples `ring_cmd` high. `ring_drv` is 0 in the cycle after `ring_cmd` is sampled low.
- R6: While `ring_drv` is 1, off-hook is accepted only after 50 consecutive ticks of `det_raw` = 1. Bursts of up to 20 ticks separated by short gaps are not reported.
- R7: On the clock edge after `hook_n` falls while ringing, `ring_drv` drops to 0 even though `ring_cmd` is still 1.
- R8: After a trip, `ring_drv` stays 0 while `ring_cmd` stays 1, even after the line returns on-hook. It rises again only after `ring_cmd` has been 0 and is then set to 1.
- R9: Setting `ring_cmd` while the line is already reported off-hook never energises `ring_drv`.
- R10: Each change of `ring_drv` starts a 30-tick blanking interval. During it, the reported hook state cannot change and the qualification count is held at zero. Counting starts at the first tick after the interval ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| det_raw | input | 1 | Sampled loop-current detect, 1 = current flowing |
| ring_cmd | input | 1 | Ring command from the control register |
| hook_n | output | 1 | Switch-hook flag, 0 = off-hook |
| led_n | output | 1 | LED drive, 0 = off-hook |
| ring_drv | output | 1 | Ring relay drive, 1 = energised |

## Verification
The hook filter is tried with four kinds of input. A clean step, observed at 7 and at 8 ticks, pins the exact length of the window. A glitch shorter than the window confirms that the count restarts. Alternating break/make dial pulses show that the filter follows each edge. Ringing-like bursts with short gaps are applied while the relay is on, which separates the long ringing window from the normal one. The relay side is driven through several command sequences: a trip observed cycle by cycle, a line that goes back on-hook with the command still held, a command re-issued after it was withdrawn, and a command given to a line that is already off-hook. A detect step applied right after a relay switch-off measures where the blanking interval ends.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic {
        HOOK_ON  = 1'b0,
        HOOK_OFF = 1'b1
    } hook_state_e;

endpackage

// File: rtl/hs_hook_filter.sv
module hs_hook_filter
    import hs_pkg::*;
#(
    parameter int NORM_TICKS = 8,
    parameter int RING_TICKS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic det_i,
    input  logic ringing_i,
    input  logic blank_i,
    output logic offhook_o
);

    localparam int MAX_TICKS = (RING_TICKS > NORM_TICKS) ? RING_TICKS : NORM_TICKS;
    localparam int CW        = $clog2(MAX_TICKS + 1);
    localparam logic [CW-1:0] NORM_LIM = CW'(NORM_TICKS);
    localparam logic [CW-1:0] RING_LIM = CW'(RING_TICKS);

    typedef struct packed {
        hook_state_e     st;
        logic [CW-1:0]   cnt;
    } filt_t;

    filt_t cur_q, nxt_d;
    logic [CW-1:0] limit;
    logic          differs;

    always_comb begin
        nxt_d   = cur_q;
        limit   = ringing_i ? RING_LIM : NORM_LIM;
        differs = (det_i != (cur_q.st == HOOK_OFF));
        if (blank_i || !differs) begin
            nxt_d.cnt = '0;
        end else if (tick_i) begin
            if (cur_q.cnt + 1'b1 >= limit) begin
                nxt_d.st  = det_i ? HOOK_OFF : HOOK_ON;
                nxt_d.cnt = '0;
            end else begin
                nxt_d.cnt = cur_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: HOOK_ON, cnt: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign offhook_o = (cur_q.st == HOOK_OFF);

    // R3: the state only moves on a tick
    assert_change_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> (cur_q.st == $past(cur_q.st)));

    // R10: blanking freezes the reported state
    assert_frozen_in_blank_R10: assert property (@(posedge clk) disable iff (!rst_n)
        blank_i |=> (cur_q.st == $past(cur_q.st)));

    // R6: the qualification count never reaches the longest window
    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.cnt < CW'(MAX_TICKS));

endmodule

// File: rtl/hs_blank_timer.sv
module hs_blank_timer #(
    parameter int BLANK_TICKS = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic relay_i,
    output logic blank_o
);

    localparam int BW = $clog2(BLANK_TICKS + 1);
    localparam logic [BW-1:0] BLANK_LOAD = BW'(BLANK_TICKS);

    typedef struct packed {
        logic          prev;
        logic [BW-1:0] left;
    } blank_t;

    blank_t cur_q, nxt_d;
    logic   edge_seen;

    always_comb begin
        nxt_d     = cur_q;
        edge_seen = (relay_i != cur_q.prev);
        nxt_d.prev = relay_i;
        if (edge_seen) begin
            nxt_d.left = BLANK_LOAD;
        end else if (tick_i && (cur_q.left != '0)) begin
            nxt_d.left = cur_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{prev: 1'b0, left: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign blank_o = edge_seen || (cur_q.left != '0);

    // R10: a relay change always restarts a full interval
    assert_reload_on_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (relay_i != cur_q.prev) |=> (cur_q.left == BLANK_LOAD));

    // R10: the remaining interval never exceeds its length
    assert_blank_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.left <= BLANK_LOAD);

endmodule

// File: rtl/hs_ring_gate.sv
module hs_ring_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic ring_cmd_i,
    input  logic offhook_i,
    output logic relay_o
);

    typedef struct packed {
        logic tripped;
        logic relay;
    } gate_t;

    gate_t cur_q, nxt_d;

    always_comb begin
        nxt_d.tripped = ring_cmd_i && (cur_q.tripped || offhook_i);
        nxt_d.relay   = ring_cmd_i && !nxt_d.tripped;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{tripped: 1'b0, relay: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign relay_o = cur_q.relay;

    // R7 / R9: a confirmed off-hook never leaves the relay energised
    assert_trip_on_offhook_R7: assert property (@(posedge clk) disable iff (!rst_n)
        offhook_i |=> !cur_q.relay);

    // R5: no drive without a command
    assert_no_drive_without_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ring_cmd_i |=> !cur_q.relay);

    // R8: a latched trip holds the relay off while the command stays set
    assert_trip_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.tripped && ring_cmd_i) |=> !cur_q.relay);

endmodule

// File: rtl/hook_supervisor.sv
module hook_supervisor #(
    parameter int NORM_TICKS  = 8,
    parameter int RING_TICKS  = 50,
    parameter int BLANK_TICKS = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ms,
    input  logic det_raw,
    input  logic ring_cmd,
    output logic hook_n,
    output logic led_n,
    output logic ring_drv
);

    logic offhook;
    logic relay;
    logic blank;

    hs_hook_filter #(
        .NORM_TICKS (NORM_TICKS),
        .RING_TICKS (RING_TICKS)
    ) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_ms),
        .det_i     (det_raw),
        .ringing_i (relay),
        .blank_i   (blank),
        .offhook_o (offhook)
    );

    hs_blank_timer #(
        .BLANK_TICKS (BLANK_TICKS)
    ) u_blank (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_ms),
        .relay_i (relay),
        .blank_o (blank)
    );

    hs_ring_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .ring_cmd_i (ring_cmd),
        .offhook_i  (offhook),
        .relay_o    (relay)
    );

    assign hook_n   = !offhook;
    assign led_n    = !offhook;
    assign ring_drv = relay;

    // R1: outputs are idle right after reset
    assert_reset_idle_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (hook_n && !ring_drv));

endmodule

// File: tb/tb_hook_supervisor.sv
module tb_hook_supervisor;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_ms = 1'b0;
    logic det_raw = 1'b0;
    logic ring_cmd = 1'b0;
    logic hook_n, led_n, ring_drv;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    hook_supervisor dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_ms  (tick_ms),
        .det_raw  (det_raw),
        .ring_cmd (ring_cmd),
        .hook_n   (hook_n),
        .led_n    (led_n),
        .ring_drv (ring_drv)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic check_led;
        check("R2", "led_n mirrors hook_n", led_n, hook_n);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_ms = 1'b1;
            @(negedge clk) tick_ms = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1", "hook_n after reset", hook_n, 1'b1);
        check("R1", "led_n after reset", led_n, 1'b1);
        check("R1", "ring_drv after reset", ring_drv, 1'b0);
        ticks(20);
        check("R1", "hook_n idle line", hook_n, 1'b1);
    endtask

    task automatic t_step;
        det_raw = 1'b1;
        ticks(7);
        check("R3", "hook_n after 7 ticks", hook_n, 1'b1);
        ticks(1);
        check("R4", "hook_n after 8 ticks", hook_n, 1'b0);
        check_led();
    endtask

    task automatic t_glitch;
        det_raw = 1'b0;
        ticks(5);
        det_raw = 1'b1;
        cycles(2);
        det_raw = 1'b0;
        ticks(7);
        check("R3", "hook_n after interrupted break", hook_n, 1'b0);
        det_raw = 1'b1;
        ticks(3);
        check("R3", "hook_n still off-hook", hook_n, 1'b0);
    endtask

    task automatic t_dial;
        for (int p = 0; p < 3; p++) begin
            det_raw = 1'b0;
            ticks(9);
            check("R4", "dial break reported", hook_n, 1'b1);
            check_led();
            det_raw = 1'b1;
            ticks(9);
            check("R4", "dial make reported", hook_n, 1'b0);
        end
        det_raw = 1'b0;
        ticks(8);
        check("R4", "hang up reported", hook_n, 1'b1);
    endtask

    task automatic t_blank;
        ring_cmd = 1'b1;
        cycles(3);
        ring_cmd = 1'b0;
        cycles(3);
        check("R5", "relay off after command drop", ring_drv, 1'b0);
        det_raw = 1'b1;
        ticks(30);
        check("R10", "hook_n frozen in blanking", hook_n, 1'b1);
        ticks(7);
        check("R10", "hook_n after 7 counted ticks", hook_n, 1'b1);
        ticks(1);
        check("R10", "hook_n after 8 counted ticks", hook_n, 1'b0);
        det_raw = 1'b0;
        ticks(8);
        check("R4", "back on-hook", hook_n, 1'b1);
    endtask

    task automatic t_ring_trip;
        @(negedge clk) ring_cmd = 1'b1;
        @(negedge clk);
        check("R5", "relay follows command", ring_drv, 1'b1);
        ticks(30);
        for (int b = 0; b < 4; b++) begin
            det_raw = 1'b1;
            ticks(20);
            det_raw = 1'b0;
            ticks(3);
        end
        check("R6", "ringing bursts rejected", hook_n, 1'b1);
        check("R6", "relay still on", ring_drv, 1'b1);
        det_raw = 1'b1;
        ticks(49);
        check("R6", "hook_n after 49 ring ticks", hook_n, 1'b1);
        @(negedge clk) tick_ms = 1'b1;
        @(negedge clk) tick_ms = 1'b0;
        check("R6", "hook_n on 50th ring tick", hook_n, 1'b0);
        check("R7", "relay one cycle before trip", ring_drv, 1'b1);
        @(negedge clk);
        check("R7", "relay tripped", ring_drv, 1'b0);
        check_led();
    endtask

    task automatic t_trip_latch;
        det_raw = 1'b0;
        ticks(38);
        check("R8", "on-hook after trip", hook_n, 1'b1);
        check("R8", "relay held off after trip", ring_drv, 1'b0);
        ring_cmd = 1'b0;
        cycles(3);
        ring_cmd = 1'b1;
        cycles(2);
        check("R8", "relay re-armed by new command", ring_drv, 1'b1);
        ring_cmd = 1'b0;
        cycles(2);
        check("R5", "relay off with command", ring_drv, 1'b0);
        ticks(35);
    endtask

    task automatic t_cmd_offhook;
        det_raw = 1'b1;
        ticks(8);
        check("R4", "off-hook before command", hook_n, 1'b0);
        ring_cmd = 1'b1;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            check("R9", "relay never energised", ring_drv, 1'b0);
        end
        ring_cmd = 1'b0;
        cycles(2);
    endtask

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(2);
        t_reset();
        t_step();
        t_glitch();
        t_dial();
        t_blank();
        t_ring_trip();
        t_trip_latch();
        t_cmd_offhook();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule